// File: doc/BRIEF.md
# Waveform Record and Playback Controller

The block moves waveform samples between a host and a byte-wide static memory, then plays them back in a continuous loop. In record mode the host offers one byte at a time. The block raises a ready flag, and the host answers with an acknowledge. The block then runs one memory access with active-low chip select and write strobe, bumps its address counter and drops the ready flag. The host clears its acknowledge before the next byte. Recording stops once the byte at the host-supplied address limit has been stored.

When the host then selects playback, the block clears its address and runs the same access loop with the read strobe in place of the write strobe. It steps through addresses zero to the limit and wraps back to zero. Each byte read is latched into an output register that feeds a converter. Dropping start ends playback after the access in progress. The sequencer holds one flip-flop per state, thirteen in all.

Top module: `wave_rec_play`

## Requirements
- R1: While reset is low, and after it is released with start low, chip select, write strobe and read strobe are all high, the ready flag is low, and the address and converter output are zero.
- R2: In record mode (mode select = 1), raising start lets the ready flag rise exactly two clock cycles later: one cycle releases the address clear, and the next cycle raises the flag.
- R3: With acknowledge high in the ready state, chip select goes low for two cycles. The strobe (write in record mode, read in playback mode) is low only in the second of these cycles. Chip select and the strobe return high on the same edge.
- R4: The address does not change during an access. It steps by one at the end of the address-pulse state, which comes two cycles after the strobe returns high. The address may also change when it is cleared.
- R5: After each access that does not reach the limit, the ready flag drops in record mode. The block waits for acknowledge to go low and then raises the flag for the next byte. Bytes land at consecutive addresses starting at zero.
- R6: The memory is full when the address equals the limit input at the address-pulse state. In record mode the block then drops the ready flag, waits for acknowledge low, and idles with no memory access while mode select stays 1.
- R7: When mode select goes to 0 after a full record, the address is cleared. The block then reads addresses 0 up to the limit in order and repeats without end, wrapping to 0 after the limit, with no writes.
- R8: The converter output register takes the memory read data at the edge where the read strobe returns high, and holds it until the next read.
- R9: When start goes low during playback, at most one further access completes. The block then makes no more accesses and the ready flag stays low.
- R10: The sequencer holds exactly one of its 13 state bits set at all times. Asserting reset in any state returns it to idle with all memory controls inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request from host |
| recMode | input | 1 | 1 = record, 0 = playback |
| hostAck | input | 1 | Host acknowledge of the ready flag |
| hostData | input | DW | Sample byte offered by the host |
| addrLimit | input | AW | Last address of the waveform |
| memRData | input | DW | Read data from the memory |
| dataReady | output | 1 | Ready flag to host (record mode) |
| memCsN | output | 1 | Memory chip select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memRdN | output | 1 | Memory read strobe, active low |
| memAddr | output | AW | Memory address |
| memWData | output | DW | Memory write data |
| dacOut | output | DW | Converter output register |

## Verification
On every cycle the assertions check the following. The state vector stays one-hot. A strobe lasts a single cycle and always follows a cycle of chip select. The address moves only on a pulse or a clear, and it returns to zero after a pulse at the limit. The address only advances after the deselect state. The exact handshake timing, the stored and replayed byte values, the wrap order and the stop on start going low all depend on whole record-and-play sequences. Only the bench shows these, sweeping several limit values including zero.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam int NUM_ST   = 13;
  localparam int S_IDLE   = 0;   // waiting for start
  localparam int S_CLR    = 1;   // address clear released
  localparam int S_RDY    = 2;   // ready flag raised
  localparam int S_SEL    = 3;   // chip select low
  localparam int S_STRB   = 4;   // strobe low (Mealy on mode)
  localparam int S_DONE   = 5;   // select and strobe high
  localparam int S_DESEL  = 6;   // memory deselected
  localparam int S_PULSE  = 7;   // address pulse, full test
  localparam int S_FULLW  = 8;   // full: wait ack low
  localparam int S_NXTW   = 9;   // not full: wait ack low
  localparam int S_HOLD   = 10;  // wait for playback select
  localparam int S_RSTRT  = 11;  // clear address for playback
  localparam int S_LOOP   = 12;  // back to ready

  typedef struct packed {
    logic cntClr;
    logic cntPulse;
    logic dacLoad;
  } wrp_strobe_t;
endpackage

// File: rtl/wrp_ctrl.sv
module wrp_ctrl
  import wrp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        recMode,
  input  logic        hostAck,
  input  logic        full,
  output wrp_strobe_t strobes,
  output logic        dataReady,
  output logic        memCsN,
  output logic        memWeN,
  output logic        memRdN
);
  logic [NUM_ST-1:0] st;
  logic [NUM_ST-1:0] nxt;
  logic              fullRec;

  assign fullRec = full & recMode;

  always_comb begin
    nxt          = '0;
    nxt[S_IDLE]  = (st[S_IDLE] | st[S_LOOP]) & ~start;
    nxt[S_CLR]   = st[S_IDLE] & start;
    nxt[S_RDY]   = st[S_CLR] | (st[S_RDY] & recMode & ~hostAck)
                 | (st[S_LOOP] & start) | st[S_RSTRT];
    nxt[S_SEL]   = st[S_RDY] & (hostAck | ~recMode);
    nxt[S_STRB]  = st[S_SEL];
    nxt[S_DONE]  = st[S_STRB];
    nxt[S_DESEL] = st[S_DONE];
    nxt[S_PULSE] = st[S_DESEL];
    nxt[S_FULLW] = (st[S_PULSE] & fullRec) | (st[S_FULLW] & hostAck);
    nxt[S_NXTW]  = (st[S_PULSE] & ~fullRec) | (st[S_NXTW] & recMode & hostAck);
    nxt[S_LOOP]  = st[S_NXTW] & (~hostAck | ~recMode);
    nxt[S_HOLD]  = (st[S_FULLW] & ~hostAck) | (st[S_HOLD] & recMode);
    nxt[S_RSTRT] = st[S_HOLD] & ~recMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= NUM_ST'(1) << S_IDLE;
    else       st <= nxt;
  end

  assign strobes.cntClr   = st[S_IDLE] | st[S_RSTRT];
  assign strobes.cntPulse = st[S_PULSE];
  assign strobes.dacLoad  = st[S_STRB] & ~recMode;

  assign dataReady = recMode & (st[S_RDY] | st[S_SEL] | st[S_STRB]
                              | st[S_DONE] | st[S_DESEL] | st[S_PULSE]);
  assign memCsN = ~(st[S_SEL] | st[S_STRB]);
  assign memWeN = ~(st[S_STRB] & recMode);
  assign memRdN = ~(st[S_STRB] & ~recMode);

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(st) == 1); // R10
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |=> memWeN); // R3
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !memRdN |=> memRdN); // R3
  AST_CS_LEADS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || !memRdN) |-> $past(!memCsN)); // R3
  AST_PULSE_AFTER_DESEL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntPulse |-> $past(st[S_DESEL])); // R4
endmodule

// File: rtl/wrp_dpath.sv
module wrp_dpath
  import wrp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  wrp_strobe_t   strobes,
  input  logic [AW-1:0] addrLimit,
  input  logic [DW-1:0] memRData,
  output logic          full,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] dacOut
);
  logic [AW-1:0] addrQ;
  logic [DW-1:0] dacQ;

  assign full = (addrQ == addrLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                addrQ <= '0;
    else if (strobes.cntClr)   addrQ <= '0;
    else if (strobes.cntPulse) addrQ <= full ? '0 : addrQ + AW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dacQ <= '0;
    else if (strobes.dacLoad) dacQ <= memRData;
  end

  assign memAddr = addrQ;
  assign dacOut  = dacQ;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.cntPulse && !strobes.cntClr) |=> $stable(memAddr)); // R4
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cntPulse && full) |=> (memAddr == '0)); // R7
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.dacLoad |=> $stable(dacOut)); // R8
endmodule

// File: rtl/wave_rec_play.sv
module wave_rec_play
  import wrp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          recMode,
  input  logic          hostAck,
  input  logic [DW-1:0] hostData,
  input  logic [AW-1:0] addrLimit,
  input  logic [DW-1:0] memRData,
  output logic          dataReady,
  output logic          memCsN,
  output logic          memWeN,
  output logic          memRdN,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWData,
  output logic [DW-1:0] dacOut
);
  wrp_strobe_t strobes;
  logic        full;

  wrp_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .recMode   (recMode),
    .hostAck   (hostAck),
    .full      (full),
    .strobes   (strobes),
    .dataReady (dataReady),
    .memCsN    (memCsN),
    .memWeN    (memWeN),
    .memRdN    (memRdN)
  );

  wrp_dpath #(.DW(DW), .AW(AW)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .addrLimit (addrLimit),
    .memRData  (memRData),
    .full      (full),
    .memAddr   (memAddr),
    .dacOut    (dacOut)
  );

  assign memWData = hostData;
endmodule

// File: tb/test_wave_rec_play.sv
module test_wave_rec_play;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start, recMode, hostAck;
  logic [DW-1:0] hostData;
  logic [AW-1:0] addrLimit;
  logic [DW-1:0] memRData;
  logic          dataReady, memCsN, memWeN, memRdN;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWData, dacOut;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  int curLim  = 0;
  int wrCount = 0;
  int playIdx = 0;
  bit trackRead = 0;
  logic          rdPrev = 1'b0;
  logic [AW-1:0] rdAddrPrev = '0;
  logic [DW-1:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_rec_play #(.DW(DW), .AW(AW)) i_wave_rec_play (
    .clk(clk), .rstN(rstN), .start(start), .recMode(recMode),
    .hostAck(hostAck), .hostData(hostData), .addrLimit(addrLimit),
    .memRData(memRData), .dataReady(dataReady), .memCsN(memCsN),
    .memWeN(memWeN), .memRdN(memRdN), .memAddr(memAddr),
    .memWData(memWData), .dacOut(dacOut)
  );

  function automatic logic [7:0] pattern(input int lim, input int idx);
    return 8'((idx * 37 + lim * 11 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // memory model
  assign memRData = (memRdN === 1'b0) ? mem[memAddr] : 8'h00;

  always @(posedge clk) begin
    if (rstN === 1'b1 && memWeN === 1'b0) begin
      chk(memAddr == AW'(wrCount), "R5 write address", int'(memAddr), wrCount);
      chk(memWData == pattern(curLim, wrCount), "R5 write data", int'(memWData),
          int'(pattern(curLim, wrCount)));
      mem[memAddr] <= memWData;
      wrCount++;
    end
    rdPrev     <= (rstN === 1'b1) && (memRdN === 1'b0);
    rdAddrPrev <= memAddr;
  end

  always @(negedge clk) begin
    if (rdPrev && trackRead) begin
      chk(int'(rdAddrPrev) == playIdx % (curLim + 1), "R7 read order",
          int'(rdAddrPrev), playIdx % (curLim + 1));
      chk(dacOut == pattern(curLim, playIdx % (curLim + 1)), "R8 dac value",
          int'(dacOut), int'(pattern(curLim, playIdx % (curLim + 1))));
      playIdx++;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 150000) begin
        nFail++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
        $finish;
      end
    end
  end

  task automatic waitReady(input logic lvl, input string tag);
    int n = 0;
    while (dataReady !== lvl && n < 500) begin tick(); n++; end
    chk(dataReady === lvl, tag, int'(dataReady), int'(lvl));
  endtask

  task automatic hostWrite(input logic [7:0] d);
    waitReady(1'b1, "R5 ready rises");
    hostData = d;
    hostAck  = 1'b1;
    waitReady(1'b0, "R5 ready falls");
    hostAck  = 1'b0;
  endtask

  task automatic runCase(input int lim);
    int n;
    int r0;
    curLim    = lim;
    addrLimit = AW'(lim);
    wrCount   = 0;
    playIdx   = 0;
    recMode   = 1'b1;
    hostData  = pattern(lim, 0);
    start     = 1'b1;
    tick();
    chk(dataReady == 1'b0, "R2 ready low after one cycle", int'(dataReady), 0);
    tick();
    chk(dataReady == 1'b1, "R2 ready high after two cycles", int'(dataReady), 1);
    chk(memCsN == 1'b1, "R3 select idle while ready", int'(memCsN), 1);
    hostAck = 1'b1;
    tick();
    chk(memCsN == 1'b0 && memWeN == 1'b1, "R3 select cycle",
        int'({memCsN, memWeN}), 1);
    tick();
    chk(memCsN == 1'b0 && memWeN == 1'b0 && memRdN == 1'b1, "R3 write strobe",
        int'({memCsN, memWeN, memRdN}), 1);
    tick();
    chk(memCsN == 1'b1 && memWeN == 1'b1, "R3 select and strobe rise",
        int'({memCsN, memWeN}), 3);
    tick();
    chk(memAddr == 0, "R4 address held in deselect", int'(memAddr), 0);
    tick();
    chk(memAddr == 0, "R4 address held in pulse", int'(memAddr), 0);
    tick();
    chk(int'(memAddr) == ((lim == 0) ? 0 : 1), "R4 address steps",
        int'(memAddr), (lim == 0) ? 0 : 1);
    chk(dataReady == 1'b0, "R5 ready drops after access", int'(dataReady), 0);
    hostAck = 1'b0;
    for (int i = 1; i <= lim; i++) hostWrite(pattern(lim, i));
    n = 0;
    repeat (6) begin
      tick();
      if (memCsN !== 1'b1 || dataReady !== 1'b0) n++;
    end
    chk(n == 0, "R6 idle when full", n, 0);
    chk(wrCount == lim + 1, "R5 byte count", wrCount, lim + 1);
    recMode   = 1'b0;
    trackRead = 1'b1;
    n = 0;
    while (playIdx < 2 * (lim + 1) + 1 && n < 3000) begin tick(); n++; end
    chk(playIdx >= 2 * (lim + 1) + 1, "R7 playback wraps", playIdx, 2 * (lim + 1) + 1);
    start = 1'b0;
    r0 = playIdx;
    repeat (20) tick();
    chk(playIdx - r0 <= 1, "R9 at most one access after stop", playIdx - r0, 1);
    chk(memCsN == 1'b1 && dataReady == 1'b0, "R9 quiet after stop",
        int'({memCsN, dataReady}), 2);
    r0 = playIdx;
    repeat (10) tick();
    chk(playIdx == r0, "R9 no further reads", playIdx, r0);
    chk(wrCount == lim + 1, "R7 no writes in playback", wrCount, lim + 1);
    trackRead = 1'b0;
    recMode   = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rstN = 1'b0; start = 1'b0; recMode = 1'b1; hostAck = 1'b0;
    hostData = '0; addrLimit = '0;
    tick(); tick();
    chk(memCsN && memWeN && memRdN && !dataReady, "R1 controls in reset",
        int'({memCsN, memWeN, memRdN, dataReady}), 14);
    rstN = 1'b1;
    tick(); tick();
    chk(memAddr == 0 && dacOut == 0, "R1 address and output zero",
        int'(memAddr) + int'(dacOut), 0);
    chk(memCsN && !dataReady, "R1 idle without start", int'({memCsN, dataReady}), 2);

    runCase(0);
    runCase(1);
    runCase(3);
    runCase(6);

    recMode = 1'b0;
    start   = 1'b1;
    repeat (7) tick();
    rstN = 1'b0;
    tick();
    chk(memCsN && memWeN && memRdN && !dataReady, "R10 reset mid playback",
        int'({memCsN, memWeN, memRdN, dataReady}), 14);
    chk(memAddr == 0 && dacOut == 0, "R10 datapath cleared",
        int'(memAddr) + int'(dacOut), 0);
    start = 1'b0;
    rstN  = 1'b1;
    repeat (5) tick();
    chk(memCsN == 1'b1, "R10 idle after reset", int'(memCsN), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule